// File: doc/BRIEF.md
# Dual-Output Cascaded Reference Divider

This block turns one reference clock into the comparison edges for two phase-locked loops. One loop is the RF loop and the other is the IF loop. The division happens in two stages that run in series. The first stage is a shared programmable divider with a 10-bit ratio. The second stage is a subdivider that counts the first stage's terminal counts and divides them again by 1 to 16. Because the stages are chained, the two comparison rates always stay in a fixed integer relation and a fixed phase relation.

A routing input picks which stage drives which loop. Each loop also has an enable input. An output pulses only while its loop is enabled. When a loop is switched on, the stage that feeds it restarts, so the loop's first comparison edge comes a known number of cycles later. New ratios are picked up only at a stage's terminal count, so a count in progress is never cut short or stretched.

Top module: `ref_cascade_div`

## Requirements
- R1: While `rst` is high at a clock edge, both reference outputs are low after that edge. Both stages restart at count zero, and both latch the ratio inputs present during reset.
- R2: The common stage divides by its latched ratio N, for N from 8 to 1023. Its terminal count occurs once every N cycles.
- R3: A common ratio input below 8 is taken as 8.
- R4: Subdivider code n (0 to 15) divides the common terminal counts by n+1. Code 0 passes every common terminal count through. A subdivider terminal count always falls in the same cycle as a common terminal count.
- R5: With `swapSel` = 1, the subdivider drives `rfRefPulse` and the common stage drives `ifRefPulse`.
- R6: With `swapSel` = 0, the subdivider drives `ifRefPulse` and the common stage drives `rfRefPulse`.
- R7: Each output is high for exactly one cycle, and it is high in the cycle after the terminal count of the stage that feeds it. An output is high only if its loop's enable was high at the edge that set it.
- R8: A change to `commonRatio` or `subCode` takes effect only when the affected stage reaches its next terminal count (or is restarted). The count in progress finishes with the old ratio.
- R9: A rising enable restarts the stage feeding that loop, and the restart is applied at the first clock edge where the enable is seen high. If the loop is common-fed, both stages restart. If the loop is sub-fed, only the subdivider restarts. The restart edge issues no pulse. With common ratio N, a common-fed loop's first pulse appears N+1 edges after the enable is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| commonRatio | input | 10 | Common stage divide ratio (values below 8 are clamped to 8) |
| subCode | input | 4 | Subdivider code n, giving a ratio of n+1 |
| swapSel | input | 1 | Routing: 1 means subdivider drives RF; 0 means subdivider drives IF |
| rfEnable | input | 1 | RF loop enable |
| ifEnable | input | 1 | IF loop enable |
| rfRefPulse | output | 1 | RF comparison pulse, one cycle wide |
| ifRefPulse | output | 1 | IF comparison pulse, one cycle wide |

## Verification
The assertions check four things on every cycle:
- every output pulse lasts exactly one cycle;
- a pulse appears only on an enabled loop;
- a subdivider terminal count lines up with a common terminal count;
- under each setting of `swapSel`, the enabled output follows the stage it is routed from.

Other properties need a bench scenario. These are the exact pulse spacings for various ratios, the clamp of small ratios, the deferral of ratio changes to the terminal count, and the latency after an enable rises. The bench shows them with a cycle model and with directed gap measurements.

// File: rtl/ref_cascade_pkg.sv
package ref_cascade_pkg;
  // Strobes the control side hands to the counter datapath.
  typedef struct packed {
    logic cmnRestart;  // restart common stage (and the subdivider behind it)
    logic subRestart;  // restart subdivider only
  } strobes_t;

  localparam int NUM_LOOPS = 2;
  localparam int LOOP_RF   = 0;
  localparam int LOOP_IF   = 1;
endpackage

// File: rtl/ref_cascade_dp.sv
module ref_cascade_dp
  import ref_cascade_pkg::*;
#(
  parameter int RATIO_W   = 10,
  parameter int SUB_W     = 4,
  parameter int MIN_RATIO = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [RATIO_W-1:0] commonRatio,
  input  logic [SUB_W-1:0]   subCode,
  input  strobes_t           strobes,
  output logic               cmnTick,
  output logic               subTick
);
  localparam logic [RATIO_W-1:0] MIN_R = RATIO_W'(MIN_RATIO);
  localparam logic [RATIO_W-1:0] ONE_R = RATIO_W'(1);
  localparam logic [SUB_W-1:0]   ONE_S = SUB_W'(1);

  logic [RATIO_W-1:0] clampRatio;
  logic [RATIO_W-1:0] activeRatio;
  logic [RATIO_W-1:0] cmnCnt;
  logic [SUB_W-1:0]   activeSub;
  logic [SUB_W-1:0]   subCnt;
  logic               cmnTerm;
  logic               subTerm;
  logic               cmnReload;
  logic               subReload;

  // Ratios below the floor are raised to it.
  assign clampRatio = (commonRatio < MIN_R) ? MIN_R : commonRatio;

  assign cmnTerm = (cmnCnt == (activeRatio - ONE_R));
  assign subTerm = (subCnt == activeSub);

  // A restart edge never issues a tick.
  assign cmnTick = cmnTerm && !strobes.cmnRestart;
  assign subTick = cmnTick && subTerm && !strobes.subRestart;

  assign cmnReload = rst || strobes.cmnRestart;
  assign subReload = rst || strobes.cmnRestart || strobes.subRestart;

  // Common stage: counts 0 .. N-1 and picks up a new ratio only on wrap.
  always_ff @(posedge clk) begin
    if (cmnReload) begin
      cmnCnt      <= '0;
      activeRatio <= clampRatio;
    end else if (cmnTerm) begin
      cmnCnt      <= '0;
      activeRatio <= clampRatio;
    end else begin
      cmnCnt <= cmnCnt + ONE_R;
    end
  end

  // Subdivider: advances once per common tick, wraps after code+1 ticks.
  always_ff @(posedge clk) begin
    if (subReload) begin
      subCnt    <= '0;
      activeSub <= subCode;
    end else if (subTick) begin
      subCnt    <= '0;
      activeSub <= subCode;
    end else if (cmnTick) begin
      subCnt <= subCnt + ONE_S;
    end
  end
endmodule

// File: rtl/ref_cascade_ctrl.sv
module ref_cascade_ctrl
  import ref_cascade_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     swapSel,
  input  logic     rfEnable,
  input  logic     ifEnable,
  input  logic     cmnTick,
  input  logic     subTick,
  output strobes_t strobes,
  output logic     rfRefPulse,
  output logic     ifRefPulse
);
  logic [NUM_LOOPS-1:0] loopEn;
  logic [NUM_LOOPS-1:0] loopPrev;
  logic [NUM_LOOPS-1:0] loopRise;
  logic [NUM_LOOPS-1:0] feedSub;
  logic [NUM_LOOPS-1:0] pulseQ;
  logic [NUM_LOOPS-1:0] wantCmnRestart;
  logic [NUM_LOOPS-1:0] wantSubRestart;

  assign loopEn[LOOP_RF] = rfEnable;
  assign loopEn[LOOP_IF] = ifEnable;

  // The RF loop is sub-fed when swapSel is set; the IF loop is sub-fed otherwise.
  assign feedSub[LOOP_RF] = swapSel;
  assign feedSub[LOOP_IF] = !swapSel;

  for (genvar i = 0; i < NUM_LOOPS; i++) begin : g_loop
    // Enable history is tracked through reset so that holding an enable high
    // across reset does not count as a rise.
    always_ff @(posedge clk) begin
      loopPrev[i] <= loopEn[i];
    end

    assign loopRise[i]       = loopEn[i] && !loopPrev[i] && !rst;
    assign wantCmnRestart[i] = loopRise[i] && !feedSub[i];
    assign wantSubRestart[i] = loopRise[i] &&  feedSub[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        pulseQ[i] <= 1'b0;
      end else begin
        pulseQ[i] <= loopEn[i] && (feedSub[i] ? subTick : cmnTick);
      end
    end
  end

  assign strobes.cmnRestart = |wantCmnRestart;
  assign strobes.subRestart = |wantSubRestart;

  assign rfRefPulse = pulseQ[LOOP_RF];
  assign ifRefPulse = pulseQ[LOOP_IF];
endmodule

// File: rtl/ref_cascade_div.sv
module ref_cascade_div
  import ref_cascade_pkg::*;
#(
  parameter int RATIO_W   = 10,
  parameter int SUB_W     = 4,
  parameter int MIN_RATIO = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [RATIO_W-1:0] commonRatio,
  input  logic [SUB_W-1:0]   subCode,
  input  logic               swapSel,
  input  logic               rfEnable,
  input  logic               ifEnable,
  output logic               rfRefPulse,
  output logic               ifRefPulse
);
  strobes_t strobes;
  logic     cmnTick;
  logic     subTick;

  ref_cascade_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .swapSel    (swapSel),
    .rfEnable   (rfEnable),
    .ifEnable   (ifEnable),
    .cmnTick    (cmnTick),
    .subTick    (subTick),
    .strobes    (strobes),
    .rfRefPulse (rfRefPulse),
    .ifRefPulse (ifRefPulse)
  );

  ref_cascade_dp #(
    .RATIO_W   (RATIO_W),
    .SUB_W     (SUB_W),
    .MIN_RATIO (MIN_RATIO)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .commonRatio (commonRatio),
    .subCode     (subCode),
    .strobes     (strobes),
    .cmnTick     (cmnTick),
    .subTick     (subTick)
  );
endmodule

// File: rtl/ref_cascade_chk.sv
module ref_cascade_chk (
  input logic clk,
  input logic rst,
  input logic swapSel,
  input logic rfEnable,
  input logic ifEnable,
  input logic cmnTick,
  input logic subTick,
  input logic rfRefPulse,
  input logic ifRefPulse
);
  // R7: a pulse only on an enabled loop
  a_r7_rf_gated: assert property (@(posedge clk) disable iff (rst)
    rfRefPulse |-> $past(rfEnable));
  a_r7_if_gated: assert property (@(posedge clk) disable iff (rst)
    ifRefPulse |-> $past(ifEnable));

  // R7: pulses are one cycle wide
  a_r7_rf_single: assert property (@(posedge clk) disable iff (rst)
    rfRefPulse |=> !rfRefPulse);
  a_r7_if_single: assert property (@(posedge clk) disable iff (rst)
    ifRefPulse |=> !ifRefPulse);

  // R4: subdivider terminal counts sit on common terminal counts
  a_r4_sub_on_cmn: assert property (@(posedge clk) disable iff (rst)
    subTick |-> cmnTick);

  // R5: routing with swapSel = 1
  a_r5_rf_from_sub: assert property (@(posedge clk) disable iff (rst)
    (swapSel && rfEnable && subTick) |=> rfRefPulse);
  a_r5_if_from_cmn: assert property (@(posedge clk) disable iff (rst)
    (swapSel && ifEnable && cmnTick) |=> ifRefPulse);

  // R6: routing with swapSel = 0
  a_r6_rf_from_cmn: assert property (@(posedge clk) disable iff (rst)
    (!swapSel && rfEnable && cmnTick) |=> rfRefPulse);
  a_r6_if_from_sub: assert property (@(posedge clk) disable iff (rst)
    (!swapSel && ifEnable && subTick) |=> ifRefPulse);
endmodule

bind ref_cascade_div ref_cascade_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .swapSel    (swapSel),
  .rfEnable   (rfEnable),
  .ifEnable   (ifEnable),
  .cmnTick    (cmnTick),
  .subTick    (subTick),
  .rfRefPulse (rfRefPulse),
  .ifRefPulse (ifRefPulse)
);

// File: tb/ref_cascade_div_tb.sv
module ref_cascade_div_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] commonRatio = 10'd8;
  logic [3:0] subCode = 4'd0;
  logic       swapSel = 1'b1;
  logic       rfEnable = 1'b1;
  logic       ifEnable = 1'b1;
  logic       rfRefPulse;
  logic       ifRefPulse;

  int    nChecks = 0;
  int    nFails = 0;
  string curReq = "R1";
  int    cycles = 0;

  always #4 clk = ~clk;  // 125 MHz

  ref_cascade_div u_dut (
    .clk         (clk),
    .rst         (rst),
    .commonRatio (commonRatio),
    .subCode     (subCode),
    .swapSel     (swapSel),
    .rfEnable    (rfEnable),
    .ifEnable    (ifEnable),
    .rfRefPulse  (rfRefPulse),
    .ifRefPulse  (ifRefPulse)
  );

  // ---- Reference model built from the requirements; pushes expected pairs ----
  logic [1:0] expQ[$];
  int mPos, mLen, mSubPos, mSubLen;
  bit mPrevRf, mPrevIf;
  bit upRf, upIf, rstC, rstS, tC, tS;

  function automatic int clampOf(input int r);
    return (r < 8) ? 8 : r;  // R3
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mPos = 0; mLen = clampOf(commonRatio);
      mSubPos = 0; mSubLen = subCode + 1;
      expQ.push_back(2'b00);
    end else begin
      upRf = rfEnable && !mPrevRf;
      upIf = ifEnable && !mPrevIf;
      // R9: common-fed loop restarts both stages, sub-fed only the subdivider
      rstC = swapSel ? upIf : upRf;
      rstS = swapSel ? upRf : upIf;
      tC = (mPos + 1 == mLen) && !rstC;
      tS = tC && (mSubPos + 1 == mSubLen) && !rstS;
      expQ.push_back({rfEnable && (swapSel ? tS : tC),
                      ifEnable && (swapSel ? tC : tS)});
      if (rstC || tC) begin
        mPos = 0; mLen = clampOf(commonRatio);
      end else mPos = mPos + 1;
      if (rstC || rstS || tS) begin
        mSubPos = 0; mSubLen = subCode + 1;
      end else if (tC) mSubPos = mSubPos + 1;
    end
    mPrevRf = rfEnable;
    mPrevIf = ifEnable;
  end

  // ---- Monitor: pops expected items and compares away from the active edge ----
  logic [1:0] expItem;
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      expItem = expQ.pop_front();
      nChecks++;
      if ({rfRefPulse, ifRefPulse} !== expItem) begin
        nFails++;
        $display("FAIL %s: {rf,if} actual=%b expected=%b at t=%0t",
                 curReq, {rfRefPulse, ifRefPulse}, expItem, $time);
      end
    end
  end

  // ---- Watchdog ----
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Count negedges until the selected output is seen high (limit guards a hang).
  task automatic waitPulse(input bit pickRf, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(pickRf ? rfRefPulse : ifRefPulse) && n < 40000);
  endtask

  task automatic measureGap(input bit pickRf, input string req, input int exp);
    int dummy, gap;
    waitPulse(pickRf, dummy);
    waitPulse(pickRf, gap);
    check(gap == exp, req, gap, exp);
  endtask

  initial begin
    int lat;
    // R1: reset state
    run(3);
    check(rfRefPulse === 1'b0, "R1", rfRefPulse, 0);
    check(ifRefPulse === 1'b0, "R1", ifRefPulse, 0);
    rst = 1'b0;
    curReq = "R2";
    run(40);
    measureGap(1'b0, "R2", 8);

    // R8: ratio change mid-count waits for the terminal count
    curReq = "R8";
    run(3);
    commonRatio = 10'd20;
    run(100);
    measureGap(1'b0, "R8", 20);

    // R3: below-floor ratio clamps to 8
    curReq = "R3";
    commonRatio = 10'd5;
    run(60);
    measureGap(1'b0, "R3", 8);
    commonRatio = 10'd0;
    run(30);
    measureGap(1'b0, "R3", 8);

    // R4 / R5: ratio 10, code 2, subdivider to RF
    curReq = "R5";
    commonRatio = 10'd10;
    subCode = 4'd2;
    run(100);
    measureGap(1'b1, "R5", 30);
    measureGap(1'b0, "R5", 10);

    // R6: swapped routing
    curReq = "R6";
    swapSel = 1'b0;
    run(70);
    measureGap(1'b1, "R6", 10);
    measureGap(1'b0, "R6", 30);

    // R4: code 0 passes through, code 15 divides by 16
    curReq = "R4";
    subCode = 4'd0;
    run(80);
    measureGap(1'b0, "R4", 10);
    subCode = 4'd15;
    run(400);
    measureGap(1'b0, "R4", 160);

    // R7: disabled loop issues nothing
    curReq = "R7";
    rfEnable = 1'b0;
    run(60);
    check(rfRefPulse === 1'b0, "R7", rfRefPulse, 0);

    // R9: raising RF (common-fed, swapSel=0) restarts; first pulse N+1 edges later
    curReq = "R9";
    commonRatio = 10'd12;
    subCode = 4'd1;
    run(30);
    rfEnable = 1'b1;
    waitPulse(1'b1, lat);
    check(lat == 13, "R9", lat, 13);
    // enable toggles at many offsets against the count
    for (int k = 0; k < 14; k++) begin
      rfEnable = 1'b0;
      run(1);
      rfEnable = 1'b1;
      run(k + 3);
      ifEnable = 1'b0;
      run(2);
      ifEnable = 1'b1;
      run(k);
    end
    swapSel = 1'b1;
    for (int k = 0; k < 14; k++) begin
      ifEnable = 1'b0;
      run(2);
      ifEnable = 1'b1;
      run(k + 5);
      rfEnable = 1'b0;
      run(1);
      rfEnable = 1'b1;
      run(k + 1);
    end
    run(60);

    // R2: top of range
    curReq = "R2";
    swapSel = 1'b0;
    commonRatio = 10'd1023;
    subCode = 4'd1;
    run(2100);
    measureGap(1'b1, "R2", 1023);
    measureGap(1'b0, "R2", 2046);

    run(5);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule